// File: doc/BRIEF.md
# Byte-Serial Word Link Port

This block moves words between two chips over a byte-wide point-to-point link. One configuration bit decides whether an instance sends or receives. A sending instance takes words from its core through a valid/ready interface. It sends each word one byte per cycle, lowest byte first, and marks every byte with a strobe. A receiving instance collects the bytes in the same order and rebuilds the words. It then offers each word to its core through a second valid/ready interface. A second configuration bit selects the word length, either four bytes (32 bits) or six bytes (48 bits).

Each direction has two word slots. The sending core can load the next word while the current one is on the wire. The receiver can finish a new word while the previous one waits for its core. The receiver returns an acknowledge level to pace the sender. The acknowledge is high while the receiver can take a complete word. The sender checks it only before the first byte of a word. Every word is followed by at least one idle link cycle, so the acknowledge has time to fall before the next word starts. Clearing the enable bit aborts any word that is only partly transferred. Whole words held in the slots are kept.

Top module: `lnk_byte_port`

## Requirements
- R1: During and after reset, with no traffic, `lk_stb_out` and `rx_wvalid` are 0. While `cfg_en` is 0, `tx_wready` and `lk_ack_out` are 0.
- R2: With `cfg_en`=1, `cfg_tx`=1 makes the port a sender: `tx_wready` may be high and `lk_ack_out` stays 0. `cfg_tx`=0 makes it a receiver: `lk_ack_out` may be high, `tx_wready` stays 0, and `lk_stb_out` never rises.
- R3: `cfg_wide`=1 gives 6 bytes per word (48 bits). `cfg_wide`=0 gives 4 bytes per word (32 bits). A received 32-bit word is delivered with bits 47:32 at zero.
- R4: The k-th strobed byte of a word (k counted from 0) carries bits [8k+7:8k] of the word. The receiver places it in the same bits.
- R5: The bytes of one word go out on consecutive cycles with `lk_stb_out` high. After the last byte of a word, `lk_stb_out` is low for at least one cycle.
- R6: The sender starts a word only if `lk_ack_in` was high in the cycle just before the first byte. The receiver drives `lk_ack_out` low while it holds a finished word in both slots, and it never sees a strobe in that state.
- R7: `tx_wready` is high while the send holding slot is empty. In the cycle after a word is accepted, `tx_wready` is 0. The core can load a word while the previous word is still being sent.
- R8: A received word is shown on `rx_wdata` with `rx_wvalid`=1. It stays there unchanged until the cycle in which `rx_wready` is 1.
- R9: With `rx_wready` held low, the receiver takes exactly two whole words before its acknowledge falls. The sender then holds a third word, and no further strobes occur.
- R10: Clearing `cfg_en` while a word is partly on the link drops that word at both ends. The next words, sent after `cfg_en` is set again, arrive intact.
- R11: With a sender looped into a receiver, random word streams of either size arrive complete and in order under random backpressure at both cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for core and link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Port enable; clearing it aborts a partial word |
| cfg_tx | input | 1 | 1 = sender, 0 = receiver |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| tx_wdata | input | 48 | Word to send |
| tx_wvalid | input | 1 | Send word offered by the core |
| tx_wready | output | 1 | Send holding slot free |
| rx_wdata | output | 48 | Received word |
| rx_wvalid | output | 1 | Received word available |
| rx_wready | input | 1 | Core takes the received word |
| lk_dout | output | 8 | Outgoing link byte |
| lk_stb_out | output | 1 | Outgoing byte strobe |
| lk_ack_in | input | 1 | Acknowledge level from the far receiver |
| lk_din | input | 8 | Incoming link byte |
| lk_stb_in | input | 1 | Incoming byte strobe |
| lk_ack_out | output | 1 | Acknowledge level to the far sender |

## Verification
The assertions rely on three conditions. First, the far end's acknowledge reaches `lk_ack_in` in the same cycle, with no register in between, so the single idle cycle after each word is enough to see it fall. Second, the far sender obeys the same one-word-per-acknowledge rule. Third, `cfg_wide` and `cfg_tx` change only while no word sits in a slot or on the wire. The stimulus wires the two instances back to back with plain connections. It changes the word size only after the enable is cleared and every word has been drained. It clears the enable mid-word only as a deliberate abort, with both instances disabled in the same cycle.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic {
    LNK_DIR_RX = 1'b0,
    LNK_DIR_TX = 1'b1
  } lnk_dir_e;

  typedef struct packed {
    logic     en;
    lnk_dir_e dir;
    logic     wide;
  } lnk_cfg_t;

endpackage

// File: rtl/lnk_size_dec.sv
module lnk_size_dec #(
  parameter int unsigned WIDE_BYTES   = 6,
  parameter int unsigned NARROW_BYTES = 4,
  parameter int unsigned CNT_W        = $clog2(WIDE_BYTES + 1)
) (
  input  logic             wide,
  output logic [CNT_W-1:0] nbytes
);

  generate
    if (WIDE_BYTES == NARROW_BYTES) begin : g_fixed
      logic unused_sel;
      assign unused_sel = wide;
      assign nbytes     = CNT_W'(WIDE_BYTES);
    end else begin : g_select
      assign nbytes = wide ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);
    end
  endgenerate

endmodule

// File: rtl/lnk_tx.sv
module lnk_tx #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WIDE_BYTES = 6,
  parameter int unsigned CNT_W      = $clog2(WIDE_BYTES + 1),
  localparam int unsigned WORD_W    = BYTE_W * WIDE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  input  logic              ack,
  output logic [BYTE_W-1:0] ld_data,
  output logic              ld_stb,
  output logic              busy
);

  logic [WORD_W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic              hold_vld_q, hold_vld_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              gap_q, gap_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              stb_q, stb_d;
  logic              accept, start, hold_en, sh_en;

  // next state
  always_comb begin
    wready = act && !hold_vld_q;
    accept = wvalid && wready;
    start  = act && hold_vld_q && (rem_q == '0) && !gap_q && ack;

    hold_en    = accept;
    hold_d     = wdata;
    hold_vld_d = hold_vld_q;
    if (accept)     hold_vld_d = 1'b1;
    else if (start) hold_vld_d = 1'b0;

    sh_en = 1'b0;
    sh_d  = sh_q;
    dat_d = dat_q;
    rem_d = rem_q;
    gap_d = 1'b0;
    stb_d = 1'b0;
    if (!act) begin
      rem_d = '0;
    end else if (start) begin
      sh_en = 1'b1;
      sh_d  = hold_q >> BYTE_W;
      dat_d = hold_q[BYTE_W-1:0];
      rem_d = nbytes - 1'b1;
      gap_d = (nbytes == CNT_W'(1));
      stb_d = 1'b1;
    end else if (rem_q != '0) begin
      sh_en = 1'b1;
      sh_d  = sh_q >> BYTE_W;
      dat_d = sh_q[BYTE_W-1:0];
      rem_d = rem_q - 1'b1;
      gap_d = (rem_q == CNT_W'(1));
      stb_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      sh_q       <= '0;
      dat_q      <= '0;
      rem_q      <= '0;
      gap_q      <= 1'b0;
      stb_q      <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      hold_vld_q <= hold_vld_d;
      if (sh_en) begin
        sh_q  <= sh_d;
        dat_q <= dat_d;
      end
      rem_q <= rem_d;
      gap_q <= gap_d;
      stb_q <= stb_d;
    end
  end

  assign ld_data = dat_q;
  assign ld_stb  = stb_q;
  assign busy    = (rem_q != '0);

endmodule

// File: rtl/lnk_rx.sv
module lnk_rx #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WIDE_BYTES = 6,
  parameter int unsigned CNT_W      = $clog2(WIDE_BYTES + 1),
  localparam int unsigned WORD_W    = BYTE_W * WIDE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ld_stb,
  output logic              ack,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready
);

  logic [WORD_W-1:0] asm_q, asm_d, asm_new, hold_q, hold_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              full_q, full_d, hold_vld_q, hold_vld_d;
  logic              take, done, pop, hold_free, hold_en;

  // next state
  always_comb begin
    take      = act && ld_stb && !full_q;
    done      = take && (idx_q == nbytes - 1'b1);
    pop       = hold_vld_q && rready;
    hold_free = !hold_vld_q || pop;

    asm_new = (idx_q == '0) ? '0 : asm_q;
    asm_new[idx_q*BYTE_W +: BYTE_W] = ld_data;
    asm_d   = take ? asm_new : asm_q;

    if (!act)      idx_d = '0;
    else if (done) idx_d = '0;
    else if (take) idx_d = idx_q + 1'b1;
    else           idx_d = idx_q;

    hold_en    = 1'b0;
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    full_d     = full_q;
    if (full_q && pop) begin
      hold_en    = 1'b1;
      hold_d     = asm_q;
      hold_vld_d = 1'b1;
      full_d     = 1'b0;
    end else if (done && hold_free) begin
      hold_en    = 1'b1;
      hold_d     = asm_new;
      hold_vld_d = 1'b1;
    end else if (done) begin
      full_d = 1'b1;
    end else if (pop) begin
      hold_vld_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q      <= '0;
      idx_q      <= '0;
      full_q     <= 1'b0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      if (take) asm_q <= asm_d;
      idx_q      <= idx_d;
      full_q     <= full_d;
      if (hold_en) hold_q <= hold_d;
      hold_vld_q <= hold_vld_d;
    end
  end

  assign ack    = act && !full_q;
  assign rdata  = hold_q;
  assign rvalid = hold_vld_q;

endmodule

// File: rtl/lnk_byte_port.sv
module lnk_byte_port
  import lnk_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned WIDE_BYTES   = 6,
  parameter int unsigned NARROW_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_en,
  input  logic                         cfg_tx,
  input  logic                         cfg_wide,
  input  logic [BYTE_W*WIDE_BYTES-1:0] tx_wdata,
  input  logic                         tx_wvalid,
  output logic                         tx_wready,
  output logic [BYTE_W*WIDE_BYTES-1:0] rx_wdata,
  output logic                         rx_wvalid,
  input  logic                         rx_wready,
  output logic [BYTE_W-1:0]            lk_dout,
  output logic                         lk_stb_out,
  input  logic                         lk_ack_in,
  input  logic [BYTE_W-1:0]            lk_din,
  input  logic                         lk_stb_in,
  output logic                         lk_ack_out
);

  localparam int unsigned WORD_W = BYTE_W * WIDE_BYTES;
  localparam int unsigned CNT_W  = $clog2(WIDE_BYTES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  lnk_cfg_t         cfg;
  logic             tx_act, rx_act, tx_busy;
  logic [CNT_W-1:0] nbytes;

  assign cfg    = '{en: cfg_en, dir: lnk_dir_e'(cfg_tx), wide: cfg_wide};
  assign tx_act = cfg.en && (cfg.dir == LNK_DIR_TX);
  assign rx_act = cfg.en && (cfg.dir == LNK_DIR_RX);

  lnk_size_dec #(
    .WIDE_BYTES  (WIDE_BYTES),
    .NARROW_BYTES(NARROW_BYTES),
    .CNT_W       (CNT_W)
  ) u_size (
    .wide  (cfg.wide),
    .nbytes(nbytes)
  );

  lnk_tx #(
    .BYTE_W    (BYTE_W),
    .WIDE_BYTES(WIDE_BYTES),
    .CNT_W     (CNT_W)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .act    (tx_act),
    .nbytes (nbytes),
    .wdata  (tx_wdata),
    .wvalid (tx_wvalid),
    .wready (tx_wready),
    .ack    (lk_ack_in),
    .ld_data(lk_dout),
    .ld_stb (lk_stb_out),
    .busy   (tx_busy)
  );

  lnk_rx #(
    .BYTE_W    (BYTE_W),
    .WIDE_BYTES(WIDE_BYTES),
    .CNT_W     (CNT_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .act    (rx_act),
    .nbytes (nbytes),
    .ld_data(lk_din),
    .ld_stb (lk_stb_in),
    .ack    (lk_ack_out),
    .rdata  (rx_wdata),
    .rvalid (rx_wvalid),
    .rready (rx_wready)
  );

endmodule

// File: rtl/lnk_byte_port_chk.sv
module lnk_byte_port_chk #(
  parameter int unsigned WORD_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_tx,
  input logic              tx_wvalid,
  input logic              tx_wready,
  input logic [WORD_W-1:0] rx_wdata,
  input logic              rx_wvalid,
  input logic              rx_wready,
  input logic              lk_stb_out,
  input logic              lk_ack_in,
  input logic              lk_stb_in,
  input logic              lk_ack_out,
  input logic              tx_busy
);

  // R2: a strobe only follows a cycle in which the port was an enabled sender
  a_r2_strobe_only_as_sender: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stb_out |-> $past(cfg_en && cfg_tx));

  // R5: bytes of a word are back to back
  a_r5_word_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stb_out && tx_busy && cfg_en && cfg_tx |=> lk_stb_out);

  // R5: idle cycle after the final byte
  a_r5_gap_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stb_out && !tx_busy |=> !lk_stb_out);

  // R6: first byte of a word only after acknowledge was high
  a_r6_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stb_out && !$past(lk_stb_out) |-> $past(lk_ack_in));

  // R6: an enabled receiver is never strobed while it withholds acknowledge
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stb_in && cfg_en && !cfg_tx |-> lk_ack_out);

  // R7: an accepted word fills the holding slot
  a_r7_full_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wvalid && tx_wready |=> !tx_wready);

  // R8: an offered received word waits unchanged
  a_r8_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wvalid && !rx_wready |=> rx_wvalid && $stable(rx_wdata));

endmodule

bind lnk_byte_port lnk_byte_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cfg_en    (cfg_en),
  .cfg_tx    (cfg_tx),
  .tx_wvalid (tx_wvalid),
  .tx_wready (tx_wready),
  .rx_wdata  (rx_wdata),
  .rx_wvalid (rx_wvalid),
  .rx_wready (rx_wready),
  .lk_stb_out(lk_stb_out),
  .lk_ack_in (lk_ack_in),
  .lk_stb_in (lk_stb_in),
  .lk_ack_out(lk_ack_out),
  .tx_busy   (tx_busy)
);

// File: tb/test_lnk_byte_port.sv
module test_lnk_byte_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk, rst_n, cfg_en, cfg_wide;
  logic [47:0] tx_wdata;
  logic        tx_wvalid, rx_wready;
  logic        tx_wready, rx_wvalid;
  logic [47:0] rx_wdata;
  logic [7:0]  lk_byte;
  logic        lk_stb, lk_ack;
  // unused sides of the two instances
  logic [47:0] s_rx_wdata, r_tx_unused_d;
  logic        s_rx_wvalid, s_ack_out, r_tx_wready, r_stb_out;
  logic [7:0]  r_dout;

  int checks = 0, failures = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign r_tx_unused_d = '0;

  lnk_byte_port i_lnk_byte_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx(1'b1), .cfg_wide(cfg_wide),
    .tx_wdata(tx_wdata), .tx_wvalid(tx_wvalid), .tx_wready(tx_wready),
    .rx_wdata(s_rx_wdata), .rx_wvalid(s_rx_wvalid), .rx_wready(1'b0),
    .lk_dout(lk_byte), .lk_stb_out(lk_stb), .lk_ack_in(lk_ack),
    .lk_din(8'h00), .lk_stb_in(1'b0), .lk_ack_out(s_ack_out)
  );

  lnk_byte_port i_lnk_byte_port_rx (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx(1'b0), .cfg_wide(cfg_wide),
    .tx_wdata(r_tx_unused_d), .tx_wvalid(1'b0), .tx_wready(r_tx_wready),
    .rx_wdata(rx_wdata), .rx_wvalid(rx_wvalid), .rx_wready(rx_wready),
    .lk_dout(r_dout), .lk_stb_out(r_stb_out), .lk_ack_in(1'b0),
    .lk_din(lk_byte), .lk_stb_in(lk_stb), .lk_ack_out(lk_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- stimulus state ----------------
  bit drv_on = 0;
  int n_req = 0, sent_req = 0;
  int vld_pct = 100, rdy_pct = 100;

  // ---------------- reference model state ----------------
  logic [47:0] q_acc[$];
  logic [47:0] q_rx[$];
  int  idx = 0, strobes = 0, received = 0, dropped = 0;
  bit  tx_acc = 0, prev_tx_acc = 0, prev_stb = 0, prev_done = 0, prev_ack = 0;
  bit  prev_rx_stall = 0;
  logic [47:0] prev_rx_data;

  function automatic logic [47:0] size_mask(input logic wide);
    return wide ? 48'hFFFF_FFFF_FFFF : 48'h0000_FFFF_FFFF;
  endfunction

  // driver
  always @(negedge clk) begin
    if (drv_on) begin
      if (tx_wvalid && tx_acc) tx_wvalid = 1'b0;
      if (!tx_wvalid && sent_req < n_req && $urandom_range(99) < vld_pct) begin
        logic [63:0] r;
        r = {$urandom, $urandom};
        tx_wdata  = r[47:0];
        tx_wvalid = 1'b1;
        sent_req++;
      end
      rx_wready = ($urandom_range(99) < rdy_pct);
    end
  end

  // cycle-by-cycle reference comparison
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      int nb;
      bit done;
      nb   = cfg_wide ? 6 : 4;
      done = 0;
      if (prev_rx_stall)
        chk(rx_wvalid && rx_wdata == prev_rx_data, "R8 held word", rx_wdata, prev_rx_data);
      if (prev_tx_acc)
        chk(!tx_wready, "R7 ready after accept", 48'(tx_wready), 48'd0);
      chk(!r_stb_out && !s_ack_out && !r_tx_wready, "R2 idle direction quiet",
          {45'd0, r_stb_out, s_ack_out, r_tx_wready}, 48'd0);
      if (!cfg_en) begin
        if ((lk_stb || idx > 0) && q_acc.size() > 0) begin
          void'(q_acc.pop_front());
          dropped++;
        end
        idx = 0;
      end else if (lk_stb) begin
        if (idx > 0) chk(prev_stb, "R5 contiguous bytes", 48'(prev_stb), 48'd1);
        else begin
          chk(!prev_done, "R5 gap between words", 48'(prev_done), 48'd0);
          chk(prev_ack, "R6 start needs ack", 48'(prev_ack), 48'd1);
        end
        if (q_acc.size() == 0) chk(0, "R4 unexpected byte", 48'(lk_byte), 48'd0);
        else begin
          logic [47:0] e;
          e = (q_acc[0] >> (8 * idx)) & 48'hFF;
          chk(48'(lk_byte) == e, "R4 byte order", 48'(lk_byte), e);
          idx++;
          strobes++;
          if (idx == nb) begin
            q_rx.push_back(q_acc.pop_front());
            idx  = 0;
            done = 1;
          end
        end
      end else if (idx > 0) begin
        chk(0, "R5 hole inside word", 48'(idx), 48'd0);
      end
      prev_stb  = lk_stb && cfg_en;
      prev_done = done;
      prev_ack  = lk_ack;
      tx_acc = tx_wvalid && tx_wready;
      prev_tx_acc = tx_acc;
      if (tx_acc) q_acc.push_back(tx_wdata & size_mask(cfg_wide));
      if (rx_wvalid && rx_wready) begin
        if (q_rx.size() == 0) chk(0, "R11 unexpected word", rx_wdata, 48'd0);
        else begin
          logic [47:0] e;
          e = q_rx.pop_front();
          chk(rx_wdata == e, cfg_wide ? "R11 R3 wide word" : "R11 R3 narrow word", rx_wdata, e);
        end
        received++;
      end
      prev_rx_stall = rx_wvalid && !rx_wready;
      prev_rx_data  = rx_wdata;
    end
  end

  task automatic wait_received(input int target);
    while (received < target) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: received=%0d expected=%0d", received, n_req - dropped);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_wide = 1'b0;
    tx_wvalid = 1'b0; tx_wdata = '0; rx_wready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    // R1: quiet after reset, disabled ports offer nothing
    chk(!lk_stb && !rx_wvalid, "R1 reset outputs", {46'd0, lk_stb, rx_wvalid}, 48'd0);
    chk(!tx_wready && !lk_ack, "R1 disabled ready/ack", {46'd0, tx_wready, lk_ack}, 48'd0);
    @(negedge clk);
    cfg_en = 1'b1;
    #3;
    // R2: sender offers ready, receiver offers ack
    chk(tx_wready && lk_ack, "R2 direction roles", {46'd0, tx_wready, lk_ack}, 48'd3);
    drv_on = 1;

    // R11/R3: narrow stream, random backpressure
    vld_pct = 70; rdy_pct = 60; n_req += 40;
    wait_received(n_req - dropped);

    // change size while disabled and drained
    @(negedge clk); cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    cfg_wide = 1'b1;
    @(negedge clk); cfg_en = 1'b1;

    // R11/R3: wide stream
    vld_pct = 80; rdy_pct = 50; n_req += 40;
    wait_received(n_req - dropped);

    // R9: receiver stalled, two words absorbed, third held in sender
    repeat (3) @(negedge clk);
    s0 = strobes;
    rdy_pct = 0; vld_pct = 100; n_req += 3;
    repeat (60) @(negedge clk);
    #3;
    chk(!lk_ack, "R9 ack low when full", 48'(lk_ack), 48'd0);
    chk(strobes - s0 == 12, "R9 bytes absorbed", 48'(strobes - s0), 48'd12);
    chk(rx_wvalid && !tx_wready, "R9 both ends holding", {46'd0, rx_wvalid, tx_wready}, 48'd2);
    rdy_pct = 100;
    wait_received(n_req - dropped);

    // R10: abort a word in flight
    repeat (3) @(negedge clk);
    s0 = strobes; n_req += 1;
    while (strobes == s0) @(negedge clk);
    @(negedge clk);
    cfg_en = 1'b0;
    repeat (6) @(negedge clk);
    #3;
    chk(!rx_wvalid, "R10 partial not delivered", 48'(rx_wvalid), 48'd0);
    chk(dropped == 1, "R10 one word dropped", 48'(dropped), 48'd1);
    @(negedge clk);
    cfg_en = 1'b1;
    n_req += 6; vld_pct = 60; rdy_pct = 70;
    wait_received(n_req - dropped);

    // back to narrow for a final mixed stream
    @(negedge clk); cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    cfg_wide = 1'b0;
    @(negedge clk); cfg_en = 1'b1;
    vld_pct = 90; rdy_pct = 30; n_req += 30;
    wait_received(n_req - dropped);
    repeat (10) @(negedge clk);
    #3;
    chk(q_acc.size() == 0 && q_rx.size() == 0, "R11 model drained",
        48'(q_acc.size() + q_rx.size()), 48'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule